// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Detection

This block is the receive half of an asynchronous serial port. It watches one serial input line, qualified by an oversampling clock enable that runs at 1, 16 or 64 times the bit rate. It recognises a start bit and checks it again at mid-bit to reject noise. It then gathers 5 to 8 data bits, least significant first, an optional odd or even parity bit, and 1, 1.5 or 2 stop bits. Each finished character goes into a holding register. The shifter is then free for the next character while the host reads the held one.

For each character the block reports a parity error and a framing error. An overrun is flagged when a character lands while the previous one is still unread. If the line stays low through a whole character, including its stop bits, the block raises a break indication. The break indication stays up until the line is seen high again. The host sets the format with static configuration inputs, which it changes only while the line is idle. It takes characters by pulsing a one-cycle read acknowledge.

The controller is a single state machine with these states:
- `ST_IDLE`: waits for a low sample.
- `ST_START`: mid-bit check of the start bit.
- `ST_DATA`: data bits.
- `ST_PARITY`: parity bit.
- `ST_STOP1`: first stop sample.
- `ST_STOP2`: second stop sample, for 1.5 or 2 stop bits.
- `ST_BREAK`: waits for the line to return high.

Its transitions are:
- IDLE→START on a low sample in 16x or 64x mode.
- IDLE→DATA on a low sample in 1x mode.
- START→IDLE when the mid-bit sample is high (glitch).
- START→DATA when the mid-bit sample is low.
- DATA→PARITY or DATA→STOP1 after the last data bit.
- PARITY→STOP1.
- STOP1→STOP2 when more than one stop bit is selected.
- STOP1 or STOP2→IDLE on delivery of a normal character.
- STOP1 or STOP2→BREAK on delivery of an all-low character.
- BREAK→IDLE on the first high sample.

Top module: `srx_top`

## Requirements
- R1: After reset, `rx_ready`, `rx_data`, `err_parity`, `err_frame`, `err_overrun` and `brk_det` are all 0.
- R2: `cfg_len` sets the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive least significant first and are right-aligned in `rx_data`, with the unused upper bits 0.
- R3: `cfg_ovs` sets the oversampling ratio.
  - 00: one tick per bit. The start bit is taken on its first low tick with no mid-bit check, and every following tick samples the next bit.
  - 01: 16 ticks per bit.
  - 10 or 11: 64 ticks per bit.
  - In the 16x and 64x modes, the start bit is re-checked 8 or 32 ticks after the first low tick. Each later bit is sampled one full bit period after the previous sample.
- R4: `cfg_stop` sets the stop length: 00 is one stop bit, 01 is 1.5 and 10 or 11 is two.
  - The first stop sample is taken at the middle of the first stop bit.
  - For 1.5 stop bits a second sample follows half a bit later (one tick in 1x mode). For two stop bits it follows a full bit later.
  - If any stop sample is low, `err_frame` is set for that character. The character is delivered at its last stop sample.
- R5: A start bit that is high again at its mid-bit check is discarded. The receiver returns to idle and no character is delivered.
- R6: With `cfg_par_en`=1, one parity bit follows the data. With `cfg_par_odd`=0 the number of ones in data plus parity must be even; with 1 it must be odd. A mismatch sets `err_parity` for that character.
- R7: A delivered character loads `rx_data` and sets `rx_ready`. `rx_data`, `err_parity` and `err_frame` hold until the next delivery. A one-cycle `rd_ack` clears `rx_ready`.
- R8: A delivery while `rx_ready` is 1, with no `rd_ack` in that cycle, sets `err_overrun`, and the new character replaces the old one. `rd_ack` clears `err_overrun`.
- R9: When every sample from the start bit through the last stop bit is low, `brk_det` is set. It is set together with a delivered character of 0x00 that has `err_frame` set.
- R10: While `brk_det` is 1 no character is delivered and no new start is sought. `brk_det` clears on the first tick that samples the line high, and reception then resumes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling clock enable, one cycle per sample |
| rxd | input | 1 | Serial line, idle high |
| cfg_ovs | input | 2 | Ticks per bit: 00 = 1, 01 = 16, 1x = 64 |
| cfg_len | input | 2 | Character length minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop | input | 2 | 00 = 1 stop bit, 01 = 1.5, 1x = 2 |
| rd_ack | input | 1 | Host has taken the held character |
| rx_data | output | 8 | Held character, right-aligned |
| rx_ready | output | 1 | Held character not yet read |
| err_parity | output | 1 | Parity mismatch on the held character |
| err_frame | output | 1 | Low stop sample on the held character |
| err_overrun | output | 1 | An unread character was overwritten |
| brk_det | output | 1 | Break condition on the line |

## Verification
Errors in the bit counter or the sample-position logic show up at the ports within one character. They appear as shifted or truncated `rx_data` and as parity or framing flags that no longer match the bits sent, so the bench varies length, parity, stop length and ratio together. A state machine stuck outside idle shows up as a missing `rx_ready` on the next frame. A wrong break or glitch path shows up either as a spurious character right after a short low pulse, or as `brk_det` failing to clear on the first high tick after a long low.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int MAX_BITS = 8;
    localparam int MIN_BITS = 5;
    localparam int OVS_MID  = 16;
    localparam int OVS_HIGH = 64;
    localparam int TCNT_W   = $clog2(OVS_HIGH);

    localparam logic [1:0] OVS_X1 = 2'b00;
    localparam logic [1:0] OVS_X16 = 2'b01;
    localparam logic [1:0] STOP_ONE = 2'b00;
    localparam logic [1:0] STOP_ONE_HALF = 2'b01;

    typedef logic [TCNT_W-1:0] tcnt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2,
        ST_BREAK
    } rx_state_t;

    // Last tick index of a full bit period for a given ratio code.
    function automatic tcnt_t full_limit(input logic [1:0] ovs);
        case (ovs)
            OVS_X1:  return '0;
            OVS_X16: return tcnt_t'(OVS_MID - 1);
            default: return tcnt_t'(OVS_HIGH - 1);
        endcase
    endfunction

    // Last tick index of a half bit period (0 in 1x mode).
    function automatic tcnt_t half_limit(input logic [1:0] ovs);
        case (ovs)
            OVS_X1:  return '0;
            OVS_X16: return tcnt_t'(OVS_MID / 2 - 1);
            default: return tcnt_t'(OVS_HIGH / 2 - 1);
        endcase
    endfunction

endpackage

// File: rtl/srx_bitclock.sv
module srx_bitclock
    import srx_pkg::*;
#(
    parameter int W = TCNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         hit
);

    logic [W-1:0] cnt_q;

    assign hit = tick && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || hit) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/srx_shifter.sv
module srx_shifter
    import srx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                shift_en,
    input  logic                bit_in,
    input  logic [1:0]          len_code,
    output logic [MAX_BITS-1:0] data_out,
    output logic                par_out
);

    localparam logic [1:0] SPAN = 2'(MAX_BITS - MIN_BITS);

    logic [MAX_BITS-1:0] sh_q;
    logic                par_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            par_q <= 1'b0;
        end else if (clear) begin
            sh_q  <= '0;
            par_q <= 1'b0;
        end else if (shift_en) begin
            sh_q  <= {bit_in, sh_q[MAX_BITS-1:1]};
            par_q <= par_q ^ bit_in;
        end
    end

    // Bits enter at the top; shorter characters are moved down to bit 0.
    always_comb begin
        data_out = sh_q >> (SPAN - len_code);
        par_out  = par_q;
    end

endmodule

// File: rtl/srx_hold.sv
module srx_hold
    import srx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [MAX_BITS-1:0] ld_data,
    input  logic                ld_perr,
    input  logic                ld_ferr,
    input  logic                rd_ack,
    output logic [MAX_BITS-1:0] data,
    output logic                ready,
    output logic                perr,
    output logic                ferr,
    output logic                ovr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data  <= '0;
            ready <= 1'b0;
            perr  <= 1'b0;
            ferr  <= 1'b0;
            ovr   <= 1'b0;
        end else begin
            if (load) begin
                data  <= ld_data;
                perr  <= ld_perr;
                ferr  <= ld_ferr;
                ready <= 1'b1;
            end else if (rd_ack) begin
                ready <= 1'b0;
            end
            if (load && ready && !rd_ack) begin
                ovr <= 1'b1;
            end else if (rd_ack) begin
                ovr <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/srx_top.sv
module srx_top
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic [1:0] cfg_ovs,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic [1:0] cfg_stop,
    input  logic       rd_ack,
    output logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       err_parity,
    output logic       err_frame,
    output logic       err_overrun,
    output logic       brk_det
);

    rx_state_t           state_q, state_d;
    tcnt_t               cur_limit;
    logic                hit;
    logic                restart;
    logic                shift_en;
    logic                hold_load;
    logic                ld_ferr;
    logic [MAX_BITS-1:0] sh_data;
    logic                sh_par;
    logic [2:0]          bit_idx_q;
    logic [2:0]          last_idx;
    logic                saw_high_q;
    logic                stop_bad_q;
    logic                perr_q;
    logic                brk_q;
    logic                two_stop;
    logic                brk_now;
    logic                start_seen;

    assign last_idx   = 3'(MIN_BITS - 1) + {1'b0, cfg_len};
    assign two_stop   = (cfg_stop != STOP_ONE);
    assign brk_now    = !saw_high_q && !rxd;
    assign start_seen = os_tick && !rxd;

    srx_bitclock #(.W(TCNT_W)) u_bitclock (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (os_tick),
        .restart (restart),
        .limit   (cur_limit),
        .hit     (hit)
    );

    srx_shifter u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (restart),
        .shift_en (shift_en),
        .bit_in   (rxd),
        .len_code (cfg_len),
        .data_out (sh_data),
        .par_out  (sh_par)
    );

    srx_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (hold_load),
        .ld_data (sh_data),
        .ld_perr (perr_q),
        .ld_ferr (ld_ferr),
        .rd_ack  (rd_ack),
        .data    (rx_data),
        .ready   (rx_ready),
        .perr    (err_parity),
        .ferr    (err_frame),
        .ovr     (err_overrun)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decode.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_seen) begin
                    state_d = (cfg_ovs == OVS_X1) ? ST_DATA : ST_START;
                end
            end
            ST_START: begin
                if (hit) begin
                    state_d = rxd ? ST_IDLE : ST_DATA;
                end
            end
            ST_DATA: begin
                if (hit && (bit_idx_q == last_idx)) begin
                    state_d = cfg_par_en ? ST_PARITY : ST_STOP1;
                end
            end
            ST_PARITY: begin
                if (hit) begin
                    state_d = ST_STOP1;
                end
            end
            ST_STOP1: begin
                if (hit) begin
                    if (two_stop) begin
                        state_d = ST_STOP2;
                    end else begin
                        state_d = brk_now ? ST_BREAK : ST_IDLE;
                    end
                end
            end
            ST_STOP2: begin
                if (hit) begin
                    state_d = brk_now ? ST_BREAK : ST_IDLE;
                end
            end
            ST_BREAK: begin
                if (os_tick && rxd) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Bit-timer limit for the current phase.
    always_comb begin
        unique case (state_q)
            ST_START: cur_limit = half_limit(cfg_ovs);
            ST_STOP2: cur_limit = (cfg_stop == STOP_ONE_HALF) ? half_limit(cfg_ovs)
                                                              : full_limit(cfg_ovs);
            default:  cur_limit = full_limit(cfg_ovs);
        endcase
    end

    // Strobes for the datapath.
    always_comb begin
        restart   = 1'b0;
        shift_en  = 1'b0;
        hold_load = 1'b0;
        ld_ferr   = 1'b0;
        unique case (state_q)
            ST_IDLE: restart = start_seen;
            ST_DATA: shift_en = hit;
            ST_STOP1: begin
                if (hit && !two_stop) begin
                    hold_load = 1'b1;
                    ld_ferr   = !rxd;
                end
            end
            ST_STOP2: begin
                if (hit) begin
                    hold_load = 1'b1;
                    ld_ferr   = stop_bad_q || !rxd;
                end
            end
            default: ;
        endcase
    end

    // Per-character bookkeeping.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx_q  <= '0;
            saw_high_q <= 1'b0;
            stop_bad_q <= 1'b0;
            perr_q     <= 1'b0;
        end else if (restart) begin
            bit_idx_q  <= '0;
            saw_high_q <= 1'b0;
            stop_bad_q <= 1'b0;
            perr_q     <= 1'b0;
        end else if (hit) begin
            unique case (state_q)
                ST_DATA: begin
                    bit_idx_q  <= bit_idx_q + 1'b1;
                    saw_high_q <= saw_high_q | rxd;
                end
                ST_PARITY: begin
                    perr_q     <= sh_par ^ rxd ^ cfg_par_odd;
                    saw_high_q <= saw_high_q | rxd;
                end
                ST_STOP1: begin
                    stop_bad_q <= !rxd;
                    saw_high_q <= saw_high_q | rxd;
                end
                default: ;
            endcase
        end
    end

    // Break indication: raised with an all-low character, dropped on a high sample.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_q <= 1'b0;
        end else if (hold_load && brk_now) begin
            brk_q <= 1'b1;
        end else if ((state_q == ST_BREAK) && os_tick && rxd) begin
            brk_q <= 1'b0;
        end
    end

    assign brk_det = brk_q;

endmodule

// File: rtl/srx_checker.sv
module srx_checker
    import srx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       os_tick,
    input logic       rxd,
    input logic [1:0] cfg_len,
    input logic       rd_ack,
    input logic [7:0] rx_data,
    input logic       rx_ready,
    input logic       err_frame,
    input logic       err_overrun,
    input logic       brk_det,
    input logic       load,
    input rx_state_t  state
);

    logic [7:0] len_mask;

    always_comb begin
        case (cfg_len)
            2'd0:    len_mask = 8'hE0;
            2'd1:    len_mask = 8'hC0;
            2'd2:    len_mask = 8'h80;
            default: len_mask = 8'h00;
        endcase
    end

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ((rx_data & $past(len_mask)) == 8'h00));

    p_no_load_in_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START) |-> !load);

    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(rx_data));

    p_ready_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> rx_ready);

    p_ovr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && rx_ready && !rd_ack) |=> err_overrun);

    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !load) |=> (!rx_ready && !err_overrun));

    p_break_char_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_det) |-> (rx_ready && err_frame && (rx_data == 8'h00)));

    p_break_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_det && !(os_tick && rxd)) |=> brk_det);

    p_no_load_in_break_r10: assert property (@(posedge clk) disable iff (!rst_n)
        brk_det |-> !load);

endmodule

bind srx_top srx_checker u_srx_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .os_tick     (os_tick),
    .rxd         (rxd),
    .cfg_len     (cfg_len),
    .rd_ack      (rd_ack),
    .rx_data     (rx_data),
    .rx_ready    (rx_ready),
    .err_frame   (err_frame),
    .err_overrun (err_overrun),
    .brk_det     (brk_det),
    .load        (hold_load),
    .state       (state_q)
);

// File: tb/tb_srx_top.sv
module tb_srx_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_ovs = 2'b01;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic [1:0] cfg_stop = 2'b00;
    logic       rd_ack = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready;
    logic       err_parity;
    logic       err_frame;
    logic       err_overrun;
    logic       brk_det;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    srx_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .os_tick     (os_tick),
        .rxd         (rxd),
        .cfg_ovs     (cfg_ovs),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .cfg_stop    (cfg_stop),
        .rd_ack      (rd_ack),
        .rx_data     (rx_data),
        .rx_ready    (rx_ready),
        .err_parity  (err_parity),
        .err_frame   (err_frame),
        .err_overrun (err_overrun),
        .brk_det     (brk_det)
    );

    typedef struct packed {
        logic [1:0] ovs;
        logic [1:0] len;
        logic       pen;
        logic       podd;
        logic [1:0] stop;
        logic [7:0] data;
        logic       flip;   // send the wrong parity bit
        logic [1:0] bad;    // 1: first stop low, 2: second stop low
        logic [7:0] xdata;
        logic       xperr;
        logic       xferr;
    } vec_t;

    localparam int NV = 11;
    //                         ovs    len   pen   podd  stop   data  flip  bad   xdata xperr xferr
    localparam vec_t VECS [NV] = '{
        '{2'b01, 2'd3, 1'b0, 1'b0, 2'b00, 8'hA5, 1'b0, 2'd0, 8'hA5, 1'b0, 1'b0},
        '{2'b01, 2'd0, 1'b1, 1'b0, 2'b00, 8'h13, 1'b0, 2'd0, 8'h13, 1'b0, 1'b0},
        '{2'b01, 2'd2, 1'b1, 1'b1, 2'b10, 8'h5A, 1'b0, 2'd0, 8'h5A, 1'b0, 1'b0},
        '{2'b00, 2'd3, 1'b1, 1'b0, 2'b00, 8'h3C, 1'b0, 2'd0, 8'h3C, 1'b0, 1'b0},
        '{2'b10, 2'd1, 1'b0, 1'b0, 2'b01, 8'h2D, 1'b0, 2'd0, 8'h2D, 1'b0, 1'b0},
        '{2'b01, 2'd3, 1'b1, 1'b0, 2'b00, 8'h81, 1'b1, 2'd0, 8'h81, 1'b1, 1'b0},
        '{2'b01, 2'd3, 1'b0, 1'b0, 2'b00, 8'h7E, 1'b0, 2'd1, 8'h7E, 1'b0, 1'b1},
        '{2'b01, 2'd3, 1'b0, 1'b0, 2'b10, 8'hC3, 1'b0, 2'd2, 8'hC3, 1'b0, 1'b1},
        '{2'b00, 2'd0, 1'b1, 1'b1, 2'b10, 8'h1F, 1'b0, 2'd0, 8'h1F, 1'b0, 1'b0},
        '{2'b01, 2'd1, 1'b1, 1'b1, 2'b01, 8'h01, 1'b1, 2'd0, 8'h01, 1'b1, 1'b0},
        '{2'b11, 2'd2, 1'b0, 1'b0, 2'b00, 8'h7F, 1'b0, 2'd0, 8'h7F, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One tick period with the line at v; the tick is sampled at the second edge.
    task automatic tick_period(input logic v);
        @(negedge clk);
        rxd = v;
        os_tick = 1'b0;
        @(negedge clk);
        os_tick = 1'b1;
    endtask

    task automatic hold_line(input logic v, input int n);
        for (int i = 0; i < n; i++) tick_period(v);
    endtask

    task automatic read_pulse();
        @(negedge clk);
        rd_ack = 1'b1;
        os_tick = 1'b0;
        @(negedge clk);
        rd_ack = 1'b0;
    endtask

    function automatic int bit_ticks(input logic [1:0] ovs);
        if (ovs == 2'b00) return 1;
        if (ovs == 2'b01) return 16;
        return 64;
    endfunction

    task automatic send_frame(input vec_t v);
        int  nb;
        int  nbits;
        logic p;
        cfg_ovs = v.ovs;
        cfg_len = v.len;
        cfg_par_en = v.pen;
        cfg_par_odd = v.podd;
        cfg_stop = v.stop;
        nb = bit_ticks(v.ovs);
        nbits = 5 + int'(v.len);
        hold_line(1'b1, 2);
        hold_line(1'b0, nb);
        p = v.podd ^ v.flip;
        for (int i = 0; i < nbits; i++) begin
            hold_line(v.data[i], nb);
            p = p ^ v.data[i];
        end
        if (v.pen) hold_line(p, nb);
        hold_line(v.bad != 2'd1, nb);
        if (v.stop == 2'b01) hold_line(1'b1, (nb > 1) ? nb / 2 : 1);
        else if (v.stop != 2'b00) hold_line(v.bad != 2'd2, nb);
        hold_line(1'b1, 4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 rx_ready", {31'd0, rx_ready}, 32'd0);
        chk("R1 rx_data", {24'd0, rx_data}, 32'd0);
        chk("R1 flags", {28'd0, err_parity, err_frame, err_overrun, brk_det}, 32'd0);

        // Table walk: lengths, ratios, parity, stop lengths, error cases
        for (int k = 0; k < NV; k++) begin
            send_frame(VECS[k]);
            chk("R7 rx_ready set", {31'd0, rx_ready}, 32'd1);
            chk("R2/R3 rx_data", {24'd0, rx_data}, {24'd0, VECS[k].xdata});
            chk("R6 err_parity", {31'd0, err_parity}, {31'd0, VECS[k].xperr});
            chk("R4 err_frame", {31'd0, err_frame}, {31'd0, VECS[k].xferr});
            chk("R8 no overrun", {31'd0, err_overrun}, 32'd0);
            read_pulse();
            chk("R7 rd_ack clears ready", {31'd0, rx_ready}, 32'd0);
            chk("R7 data held after read", {24'd0, rx_data}, {24'd0, VECS[k].xdata});
        end

        // R5: low pulse shorter than half a bit is rejected (16x)
        cfg_ovs = 2'b01; cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_stop = 2'b00;
        hold_line(1'b1, 4);
        hold_line(1'b0, 7);
        hold_line(1'b1, 200);
        chk("R5 glitch gives no character", {31'd0, rx_ready}, 32'd0);
        send_frame(VECS[0]);
        chk("R5 receive after glitch", {24'd0, rx_data}, 32'hA5);
        read_pulse();

        // R8: second character before read
        send_frame(VECS[0]);
        v = VECS[0];
        v.data = 8'h3C;
        send_frame(v);
        chk("R8 overrun set", {31'd0, err_overrun}, 32'd1);
        chk("R8 newer data kept", {24'd0, rx_data}, 32'h3C);
        read_pulse();
        chk("R8 overrun cleared by read", {31'd0, err_overrun}, 32'd0);
        chk("R8 ready cleared by read", {31'd0, rx_ready}, 32'd0);

        // R9/R10: break on a line held low
        cfg_ovs = 2'b01; cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_stop = 2'b00;
        hold_line(1'b1, 4);
        hold_line(1'b0, 170);
        chk("R9 break flagged", {31'd0, brk_det}, 32'd1);
        chk("R9 break character", {24'd0, rx_data}, 32'd0);
        chk("R9 break framing", {31'd0, err_frame}, 32'd1);
        chk("R9 break ready", {31'd0, rx_ready}, 32'd1);
        read_pulse();
        hold_line(1'b0, 300);
        chk("R10 break held while low", {31'd0, brk_det}, 32'd1);
        chk("R10 no character while low", {31'd0, rx_ready}, 32'd0);
        hold_line(1'b1, 1);
        @(negedge clk);
        chk("R10 break clears on high", {31'd0, brk_det}, 32'd0);
        send_frame(VECS[2]);
        chk("R10 receive after break", {24'd0, rx_data}, 32'h5A);
        chk("R10 clean frame after break", {30'd0, err_frame, err_parity}, 32'd0);
        read_pulse();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule